// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of device slots onto a few shared interrupt lines. Every slot has four request pins. A fixed routing rule assigns each pin of each slot to one shared line. Each line keeps a count of the pins that currently drive it high, and the line output is asserted while that count is nonzero.

The block stores the last level seen on every pin. A counter moves only when a pin's level differs from its stored copy, so a request that is held high for many cycles is counted once. All level changes that arrive in one cycle, from any number of pins, are added into their counters in that same cycle.

A per-slot setup strobe brings a slot back to its initial state. While the strobe is high, every stored level of that slot is cleared, any pin of that slot that was counted as high is taken out of its line's count, and that slot's pin inputs are ignored for that cycle.

Top module: `shared_irq_merge`

## Requirements
- R1: Bit `4*d + p` of `dev_lvl_i` is request pin p (0 to 3) of slot d. Each pin is a single-bit level.
- R2: Pin p of slot d is routed to line `(d + p) mod NUM_LINES`, and it affects no other line.
- R3: `line_irq_o[L]` is high exactly while at least one counted pin routed to L is high. A pin change sampled at a rising clock edge appears on the output just after that edge.
- R4: A pin that is held at the same level causes no counter change. A pin held high for many cycles and then released once drops its line, provided no other pin holds that line.
- R5: A rising pin adds one to its line's count and a falling pin subtracts one. A line shared by several high pins stays high until the last of them falls.
- R6: All rises and falls sampled at the same edge are summed into their counters at that edge. A rise and a fall on the same line in one cycle leave the line high with no low cycle. A line with no events does not change.
- R7: While `slot_setup_i[d]` is high at an edge, every stored level of slot d is cleared and each previously high pin of d is subtracted from its line. The pin inputs of d are ignored at that edge, and they are counted again from the next edge on.
- R8: Reset (`rst_n` low, asynchronous) clears every stored level and every counter, so all lines are low. Pins that are still high after reset are counted at the first edge after reset ends.
- R9: A counter can hold every pin of every slot without wrapping. With every pin high, each line stays high until its last pin falls, and a counter never goes below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_lvl_i | input | NUM_DEV*4 | Request levels, four pins per slot, slot-major |
| slot_setup_i | input | NUM_DEV | Per-slot strobe that clears the slot's stored levels |
| line_irq_o | output | NUM_LINES | Shared interrupt lines, high while their count is nonzero |

## Verification
Two functions can land on the same line at the same edge: a count increase from one pin and a count decrease from another, and a slot setup that retires a stored high level while another slot holds the same line. The bench provokes the first by dropping one pin and raising another pin routed to the same line in the same cycle. It provokes the second by strobing setup on a slot that shares a line with a different, still-active slot. In both cases the line must stay high without a low cycle. A later single release must then drop the line, which shows that the counter holds exactly the number of active sources.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int unsigned PINS_PER_DEV = 4;

  // Line that a given slot/pin pair feeds.
  function automatic int unsigned route_line(input int unsigned slot,
                                             input int unsigned pin,
                                             input int unsigned n_lines);
    return (slot + pin) % n_lines;
  endfunction
endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track #(
  parameter int unsigned PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            setup_i,
  input  logic [PINS-1:0] lvl_i,
  output logic [PINS-1:0] rise_o,
  output logic [PINS-1:0] fall_o,
  output logic [PINS-1:0] held_o
);
  logic [PINS-1:0] held_q;

  always_comb begin
    if (setup_i) begin
      rise_o = '0;
      fall_o = held_q;
    end else begin
      rise_o = lvl_i & ~held_q;
      fall_o = ~lvl_i & held_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (setup_i) held_q <= '0;
    else              held_q <= lvl_i;
  end

  assign held_o = held_q;
endmodule

// File: rtl/irq_tally.sv
module irq_tally #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = 4
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] n_o
);
  always_comb begin
    n_o = '0;
    for (int i = 0; i < int'(W); i++) n_o = n_o + CW'(bits_i[i]);
  end
endmodule

// File: rtl/irq_line_count.sv
module irq_line_count #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ups_i,
  input  logic [CW-1:0] dns_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] cur,
                                         input logic [CW-1:0] up,
                                         input logic [CW-1:0] dn);
    return cur + up - dn;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= step(cnt_q, ups_i, dns_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/shared_irq_merge.sv
module shared_irq_merge
  import irq_merge_pkg::*;
#(
  parameter int unsigned NUM_DEV   = 8,
  parameter int unsigned NUM_LINES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_DEV*PINS_PER_DEV-1:0] dev_lvl_i,
  input  logic [NUM_DEV-1:0]             slot_setup_i,
  output logic [NUM_LINES-1:0]           line_irq_o
);
  localparam int unsigned NSRC  = NUM_DEV * PINS_PER_DEV;
  localparam int unsigned CNT_W = $clog2(NSRC + 1);

  // Per-pin events and stored levels, visible to the checker.
  logic [NSRC-1:0] rise_all;
  logic [NSRC-1:0] fall_all;
  logic [NSRC-1:0] pin_held;

  logic [NUM_LINES-1:0][NSRC-1:0]  up_mask;
  logic [NUM_LINES-1:0][NSRC-1:0]  dn_mask;
  logic [NUM_LINES-1:0][CNT_W-1:0] line_ups;
  logic [NUM_LINES-1:0][CNT_W-1:0] line_dns;
  logic [NUM_LINES-1:0][CNT_W-1:0] line_cnt;

  for (genvar d = 0; d < int'(NUM_DEV); d++) begin : g_dev
    irq_pin_track #(.PINS(PINS_PER_DEV)) trk_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .setup_i (slot_setup_i[d]),
      .lvl_i   (dev_lvl_i[d*PINS_PER_DEV +: PINS_PER_DEV]),
      .rise_o  (rise_all[d*PINS_PER_DEV +: PINS_PER_DEV]),
      .fall_o  (fall_all[d*PINS_PER_DEV +: PINS_PER_DEV]),
      .held_o  (pin_held[d*PINS_PER_DEV +: PINS_PER_DEV])
    );
  end

  for (genvar l = 0; l < int'(NUM_LINES); l++) begin : g_line
    for (genvar s = 0; s < int'(NSRC); s++) begin : g_src
      localparam int unsigned LN =
        route_line(s / PINS_PER_DEV, s % PINS_PER_DEV, NUM_LINES);
      assign up_mask[l][s] = (int'(LN) == l) ? rise_all[s] : 1'b0;
      assign dn_mask[l][s] = (int'(LN) == l) ? fall_all[s] : 1'b0;
    end

    irq_tally #(.W(NSRC), .CW(CNT_W)) up_tally_i (
      .bits_i (up_mask[l]),
      .n_o    (line_ups[l])
    );
    irq_tally #(.W(NSRC), .CW(CNT_W)) dn_tally_i (
      .bits_i (dn_mask[l]),
      .n_o    (line_dns[l])
    );
    irq_line_count #(.CW(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .ups_i (line_ups[l]),
      .dns_i (line_dns[l]),
      .cnt_o (line_cnt[l])
    );

    assign line_irq_o[l] = (line_cnt[l] != '0);
  end
endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
  parameter int unsigned NUM_DEV   = 8,
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned CNT_W     = 6
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_DEV-1:0]              slot_setup_i,
  input logic [NUM_DEV*4-1:0]            pin_held,
  input logic [NUM_LINES-1:0][CNT_W-1:0] line_ups,
  input logic [NUM_LINES-1:0][CNT_W-1:0] line_dns,
  input logic [NUM_LINES-1:0][CNT_W-1:0] line_cnt,
  input logic [NUM_LINES-1:0]            line_irq_o
);
  localparam int unsigned NSRC = NUM_DEV * 4;

  // R6
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ups == '0 && line_dns == '0) |=> $stable(line_irq_o));

  for (genvar l = 0; l < int'(NUM_LINES); l++) begin : g_l
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(line_cnt[l]) <= int'(NSRC));
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cnt[l] == '0) |-> (line_dns[l] == '0));
    // R5
    rise_sets_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_ups[l] != '0) |=> line_irq_o[l]);
    // R3
    drop_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_irq_o[l]) |-> ($past(line_dns[l]) != '0));
  end

  for (genvar d = 0; d < int'(NUM_DEV); d++) begin : g_d
    // R7
    setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_setup_i[d] |=> (pin_held[d*4 +: 4] == 4'b0000));
  end
endmodule

bind shared_irq_merge irq_merge_chk #(
  .NUM_DEV   (NUM_DEV),
  .NUM_LINES (NUM_LINES),
  .CNT_W     (CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .slot_setup_i (slot_setup_i),
  .pin_held     (pin_held),
  .line_ups     (line_ups),
  .line_dns     (line_dns),
  .line_cnt     (line_cnt),
  .line_irq_o   (line_irq_o)
);

// File: tb/shared_irq_merge_tb_top.sv
module shared_irq_merge_tb_top;
  localparam int ND = 8;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [ND*4-1:0] lvl = '0;
  logic [ND-1:0] setup = '0;
  logic [NL-1:0] lines;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shared_irq_merge #(.NUM_DEV(ND), .NUM_LINES(NL)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_lvl_i    (lvl),
    .slot_setup_i (setup),
    .line_irq_o   (lines)
  );

  function automatic int pidx(input int d, input int p);
    return d * 4 + p;
  endfunction

  function automatic logic [NL-1:0] onehot_line(input int d, input int p);
    logic [NL-1:0] v = '0;
    v[(d + p) % NL] = 1'b1;
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [NL-1:0] exp);
    n_chk++;
    if (lines !== exp) begin
      n_fail++;
      $display("FAIL %s: lines=%b expected=%b", req, lines, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    chk("R8 in reset", 4'b0000);
    rst_n = 1'b1;
    tick();
    chk("R8 after reset", 4'b0000);
  endtask

  task automatic t_routing();
    for (int d = 0; d < ND; d++) begin
      for (int p = 0; p < 4; p++) begin
        lvl = '0;
        lvl[pidx(d, p)] = 1'b1;
        tick();
        chk("R1 R2 route", onehot_line(d, p));
        lvl = '0;
        tick();
        chk("R3 release", 4'b0000);
      end
    end
  endtask

  task automatic t_share();
    lvl[pidx(0, 1)] = 1'b1;
    lvl[pidx(3, 2)] = 1'b1;
    tick();
    chk("R5 two on line1", 4'b0010);
    lvl[pidx(0, 1)] = 1'b0;
    tick();
    chk("R5 one left", 4'b0010);
    lvl[pidx(3, 2)] = 1'b0;
    tick();
    chk("R5 last dropped", 4'b0000);
  endtask

  task automatic t_hold();
    lvl[pidx(5, 3)] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R4 held", 4'b0001);
    end
    lvl[pidx(5, 3)] = 1'b0;
    tick();
    chk("R4 single release", 4'b0000);
  endtask

  task automatic t_simul();
    lvl[pidx(0, 0)] = 1'b1;
    tick();
    chk("R6 setup line0", 4'b0001);
    lvl[pidx(0, 0)] = 1'b0;
    lvl[pidx(1, 3)] = 1'b1;
    tick();
    chk("R6 swap same line", 4'b0001);
    lvl[pidx(1, 3)] = 1'b0;
    tick();
    chk("R6 swap released", 4'b0000);
    lvl = '1;
    tick();
    chk("R6 all rise", 4'b1111);
    lvl = '0;
    for (int p = 0; p < 4; p++) lvl[pidx(0, p)] = 1'b1;
    tick();
    chk("R9 one per line kept", 4'b1111);
    lvl[pidx(0, 0)] = 1'b0;
    tick();
    chk("R9 line0 last gone", 4'b1110);
    lvl = '0;
    tick();
    chk("R6 all fall", 4'b0000);
  endtask

  task automatic t_setup();
    lvl[pidx(2, 0)] = 1'b1;
    tick();
    chk("R7 pre", 4'b0100);
    setup[2] = 1'b1;
    tick();
    chk("R7 setup retires", 4'b0000);
    setup[2] = 1'b0;
    tick();
    chk("R7 recount", 4'b0100);
    lvl[pidx(2, 0)] = 1'b0;
    tick();
    chk("R7 release", 4'b0000);
    lvl[pidx(2, 1)] = 1'b1;
    lvl[pidx(7, 0)] = 1'b1;
    tick();
    chk("R7 shared pre", 4'b1000);
    setup[2] = 1'b1;
    tick();
    chk("R7 shared kept", 4'b1000);
    setup[2] = 1'b0;
    lvl[pidx(2, 1)] = 1'b0;
    tick();
    chk("R7 shared still", 4'b1000);
    lvl[pidx(7, 0)] = 1'b0;
    tick();
    chk("R7 count exact", 4'b0000);
    setup[4] = 1'b1;
    lvl[pidx(4, 0)] = 1'b1;
    tick();
    chk("R7 input ignored", 4'b0000);
    setup[4] = 1'b0;
    tick();
    chk("R7 counted after", 4'b0001);
    lvl = '0;
    tick();
    chk("R7 clean", 4'b0000);
  endtask

  task automatic t_midreset();
    lvl[pidx(0, 0)] = 1'b1;
    lvl[pidx(1, 0)] = 1'b1;
    tick();
    chk("R8 pre", 4'b0011);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear", 4'b0000);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R8 recount", 4'b0011);
    lvl = '0;
    tick();
    chk("R8 release", 4'b0000);
  endtask

  initial begin
    t_reset();
    t_routing();
    t_share();
    t_hold();
    t_simul();
    t_setup();
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule